// File: doc/BRIEF.md
# Multi-Channel Service Request Aggregator

This block gathers event pulses from up to sixteen serial channels into five request words that a host reads over a simple synchronous register port. Each word covers one kind of event: receive data ready, transmit space available, command completed, modem line change and line error. Bit n of every word belongs to channel n. A pulse from a channel sets its bit, and the bit stays set until the host clears it. The host clears a word with an exchange access. In that access the old contents come back on the read bus and the supplied value (normally zero) is written in the same clock edge, so no event can fall between the read and the clear.

The host interrupt is a doorbell flag. The doorbell is raised when an enabled request bit is pending and no earlier interrupt is still waiting for its global acknowledge. The host clears the doorbell with a write-one access. It then re-arms signalling by writing the acknowledge code to a separate register. A per-category enable mask decides which request words can raise the doorbell. Request words whose category is masked keep collecting bits.

Each channel also has a command word. The host writes a nonzero value to it and the word is presented to the channel. When the channel reports completion, the word returns to zero, the channel's status value is captured for the host to read, and the channel's bit is set in the command request word.

Top module: `svc_req_agg`

## Requirements
- R1: Request words are located at addresses 0x00 to 0x04, in this order: receive, transmit, command, modem, error. Bit n is channel n. A one-cycle pulse on channel n's event input sets bit n at the next clock edge, and set bits accumulate until the host writes the word.
- R2: An exchange is an access with bus_rd and bus_wr both high, addressed to a request word. In the cycle after the access, bus_rdata holds the word's previous contents, and the word takes the value of bus_wdata.
- R3: If an event pulse for a bit arrives in the same cycle as an exchange on that word, the bit is set after the exchange, whatever value was written.
- R4: A read with bus_wr low does not change the word that is read.
- R5: The doorbell is raised when an enabled request bit is set and no acknowledge is outstanding. It rises at the clock edge after the edge that set the bit, and irq follows the doorbell. Raising the doorbell also marks an acknowledge as outstanding.
- R6: Writing a value with bit 0 set to address 0x05 clears the doorbell. Reading address 0x05 returns the doorbell in bit 0 and the acknowledge-outstanding flag in bit 1. No new doorbell is raised while the acknowledge is outstanding.
- R7: Writing exactly 0x0001 to address 0x06 clears the outstanding acknowledge, and a new doorbell may then be raised at the next edge. Any other value written to 0x06 has no effect.
- R8: Address 0x07 holds the enable mask in bits 4:0, one bit per category, in the same order as the request words. Its reset value is 0x1F. The request bits of a disabled category still accumulate but do not raise the doorbell.
- R9: The command word of channel n is at address 0x20+n and is driven on cmd_word. A pulse on cmd_done[n] clears that word to zero, captures cmd_status slice n into the status word at 0x30+n, and sets bit n of the command request word. If a host write to the command word arrives in the same cycle, the completion takes priority.
- R10: Reset clears all request words, the doorbell, the acknowledge flag, the command words, the status words and bus_rdata, and sets the mask to 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_rx | input | NUM_CH | Receive-data event pulses, one per channel |
| ev_tx | input | NUM_CH | Transmit-space event pulses |
| ev_modem | input | NUM_CH | Modem line change event pulses |
| ev_err | input | NUM_CH | Line error event pulses |
| cmd_done | input | NUM_CH | Command completion pulses |
| cmd_status | input | NUM_CH*CW | Completion status per channel, captured on cmd_done |
| cmd_word | output | NUM_CH*CW | Current command word per channel |
| bus_rd | input | 1 | Read strobe; together with bus_wr it forms an exchange |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data, valid the cycle after bus_rd |
| irq | output | 1 | Doorbell interrupt to the host |

## Verification
A table of pulse pairs is applied to every category. The pairs are overlapping, disjoint, single-bit and edge-channel patterns. Comparing the exchange result with the OR of each pair shows whether bits accumulate rather than being overwritten, whether the categories are kept separate, and whether the clear is complete. Directed sequences then step through the doorbell handshake. They show whether a cleared doorbell stays low while an acknowledge is outstanding, and whether a wrong acknowledge code is refused. Further sequences separate masked accumulation from doorbell raising, check that an event pulse colliding with an exchange is kept, and check that command completion takes priority over the command word.

// File: rtl/svc_agg_pkg.sv
package svc_agg_pkg;
  localparam int NUM_CAT = 5;
  localparam int AW      = 6;

  typedef enum logic [2:0] {
    CAT_RX  = 3'd0,
    CAT_TX  = 3'd1,
    CAT_CMD = 3'd2,
    CAT_MDM = 3'd3,
    CAT_ERR = 3'd4
  } cat_e;

  localparam logic [AW-1:0] A_DOORBELL = 6'h05;
  localparam logic [AW-1:0] A_GACK     = 6'h06;
  localparam logic [AW-1:0] A_MASK     = 6'h07;
  localparam logic [1:0]    A_CMD_HI   = 2'b10;
  localparam logic [1:0]    A_STS_HI   = 2'b11;
  localparam logic [15:0]   GACK_CODE  = 16'h0001;
endpackage

// File: rtl/svc_req_word.sv
module svc_req_word #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wdata,
  output logic [NUM_CH-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= (wr_en ? wdata : word_q) | ev;
  end

  // R3
  ev_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (|ev) |=> ((word_q & $past(ev)) == $past(ev)));
endmodule

// File: rtl/svc_doorbell.sv
module svc_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic any_req,
  input  logic db_clr,
  input  logic gack,
  output logic db_q,
  output logic ack_pend_q
);
  logic raise;
  assign raise = any_req && !ack_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      db_q       <= 1'b0;
      ack_pend_q <= 1'b0;
    end else if (raise) begin
      db_q       <= 1'b1;
      ack_pend_q <= 1'b1;
    end else begin
      if (db_clr) db_q       <= 1'b0;
      if (gack)   ack_pend_q <= 1'b0;
    end
  end

  // R6
  db_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(db_q) |-> !$past(ack_pend_q));
  // R5
  db_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(db_q) |-> $past(any_req));
endmodule

// File: rtl/svc_cmd_bank.sv
module svc_cmd_bank #(
  parameter int NUM_CH = 16,
  parameter int CW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_we,
  input  logic [3:0]           host_idx,
  input  logic [CW-1:0]        host_wdata,
  input  logic [NUM_CH-1:0]    done,
  input  logic [NUM_CH*CW-1:0] status_in,
  output logic [NUM_CH*CW-1:0] cmd_flat,
  output logic [NUM_CH*CW-1:0] sts_flat
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CW-1:0] cmd_q, sts_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cmd_q <= '0;
        sts_q <= '0;
      end else if (done[i]) begin
        cmd_q <= '0;
        sts_q <= status_in[i*CW +: CW];
      end else if (host_we && host_idx == 4'(i)) begin
        cmd_q <= host_wdata;
      end
    end
    assign cmd_flat[i*CW +: CW] = cmd_q;
    assign sts_flat[i*CW +: CW] = sts_q;

    // R9
    cmd_clear_chk: assert property (@(posedge clk) disable iff (rst)
      done[i] |=> (cmd_flat[i*CW +: CW] == '0));
  end
endmodule

// File: rtl/svc_req_agg.sv
module svc_req_agg
  import svc_agg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 16,
  parameter int CW     = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CH-1:0]    ev_rx,
  input  logic [NUM_CH-1:0]    ev_tx,
  input  logic [NUM_CH-1:0]    ev_modem,
  input  logic [NUM_CH-1:0]    ev_err,
  input  logic [NUM_CH-1:0]    cmd_done,
  input  logic [NUM_CH*CW-1:0] cmd_status,
  output logic [NUM_CH*CW-1:0] cmd_word,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq
);
  logic [NUM_CH-1:0]    ev_bus [NUM_CAT];
  logic [NUM_CH-1:0]    req_w  [NUM_CAT];
  logic [NUM_CAT-1:0]   mask_q;
  logic                 any_req, db_q, ack_pend_q, db_clr, gack, cmd_we;
  logic [NUM_CH*CW-1:0] sts_flat;
  logic [DW-1:0]        rd_mux;

  assign ev_bus[CAT_RX]  = ev_rx;
  assign ev_bus[CAT_TX]  = ev_tx;
  assign ev_bus[CAT_CMD] = cmd_done;
  assign ev_bus[CAT_MDM] = ev_modem;
  assign ev_bus[CAT_ERR] = ev_err;

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    svc_req_word #(.NUM_CH(NUM_CH)) u_word (
      .clk    (clk),
      .rst    (rst),
      .ev     (ev_bus[c]),
      .wr_en  (bus_wr && bus_addr == AW'(c)),
      .wdata  (bus_wdata[NUM_CH-1:0]),
      .word_q (req_w[c])
    );
  end

  always_comb begin
    any_req = 1'b0;
    for (int c = 0; c < NUM_CAT; c++)
      any_req = any_req | (mask_q[c] && (|req_w[c]));
  end

  always_ff @(posedge clk) begin
    if (rst)                             mask_q <= '1;
    else if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NUM_CAT-1:0];
  end

  assign db_clr = bus_wr && bus_addr == A_DOORBELL && bus_wdata[0];
  assign gack   = bus_wr && bus_addr == A_GACK && bus_wdata == DW'(GACK_CODE);
  assign cmd_we = bus_wr && bus_addr[5:4] == A_CMD_HI;

  svc_doorbell u_db (
    .clk        (clk),
    .rst        (rst),
    .any_req    (any_req),
    .db_clr     (db_clr),
    .gack       (gack),
    .db_q       (db_q),
    .ack_pend_q (ack_pend_q)
  );
  assign irq = db_q;

  svc_cmd_bank #(.NUM_CH(NUM_CH), .CW(CW)) u_cmd (
    .clk        (clk),
    .rst        (rst),
    .host_we    (cmd_we),
    .host_idx   (bus_addr[3:0]),
    .host_wdata (bus_wdata[CW-1:0]),
    .done       (cmd_done),
    .status_in  (cmd_status),
    .cmd_flat   (cmd_word),
    .sts_flat   (sts_flat)
  );

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CAT; c++)
      if (bus_addr == AW'(c)) rd_mux[NUM_CH-1:0] = req_w[c];
    if (bus_addr == A_DOORBELL) rd_mux[1:0] = {ack_pend_q, db_q};
    if (bus_addr == A_MASK)     rd_mux[NUM_CAT-1:0] = mask_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == {A_CMD_HI, 4'(i)}) rd_mux[CW-1:0] = cmd_word[i*CW +: CW];
      if (bus_addr == {A_STS_HI, 4'(i)}) rd_mux[CW-1:0] = sts_flat[i*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R2
  xchg_old_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == '0) |=> (bus_rdata[NUM_CH-1:0] == $past(req_w[0])));
  // R4
  rd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr == '0 && ev_rx == '0) |=> $stable(req_w[0]));
endmodule

// File: tb/svc_req_agg_test.sv
module svc_req_agg_test;
  localparam int CLK_P  = 10;
  localparam int NUM_CH = 16;
  localparam int DW     = 16;
  localparam int CW     = 16;

  typedef struct packed {
    logic [2:0]  cat;
    logic [15:0] a;
    logic [15:0] b;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd0, 16'h00F0, 16'h0F00},
    '{3'd1, 16'h8001, 16'h8001},
    '{3'd2, 16'h0001, 16'h0000},
    '{3'd3, 16'hAAAA, 16'h5555},
    '{3'd4, 16'h8000, 16'h0003},
    '{3'd0, 16'h0000, 16'h4000},
    '{3'd3, 16'h1234, 16'h0200},
    '{3'd4, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [NUM_CH-1:0] ev_rx = '0, ev_tx = '0, ev_modem = '0, ev_err = '0, cmd_done = '0;
  logic [NUM_CH*CW-1:0] cmd_status = '0;
  logic [NUM_CH*CW-1:0] cmd_word;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  svc_req_agg #(.NUM_CH(NUM_CH), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .ev_rx(ev_rx), .ev_tx(ev_tx), .ev_modem(ev_modem),
    .ev_err(ev_err), .cmd_done(cmd_done), .cmd_status(cmd_status),
    .cmd_word(cmd_word), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic rd, input logic wr, input logic [5:0] a,
                        input logic [15:0] d, output logic [15:0] q);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    q = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] cat, input logic [15:0] m);
    case (cat)
      3'd0: ev_rx = m;
      3'd1: ev_tx = m;
      3'd2: cmd_done = m;
      3'd3: ev_modem = m;
      default: ev_err = m;
    endcase
    @(negedge clk);
    ev_rx = '0; ev_tx = '0; cmd_done = '0; ev_modem = '0; ev_err = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] q;
    @(negedge clk);
    do_reset();

    // R10 reset state
    check("R10 irq", irq, 0);
    check("R10 rdata", bus_rdata, 0);
    for (int c = 0; c < 5; c++) begin
      access(1, 0, 6'(c), 0, q);
      check("R10 word", q, 0);
    end
    access(1, 0, 6'h05, 0, q); check("R10 doorbell/ack", q, 0);
    access(1, 0, 6'h07, 0, q); check("R10 mask", q, 16'h001F);

    // R1 R2 table: two pulses accumulate, exchange returns OR, then cleared
    foreach (VECS[k]) begin
      pulse(VECS[k].cat, VECS[k].a);
      pulse(VECS[k].cat, VECS[k].b);
      access(1, 1, 6'(VECS[k].cat), 16'h0000, q);
      check("R1 R2 xchg", q, VECS[k].a | VECS[k].b);
      access(1, 0, 6'(VECS[k].cat), 16'h0000, q);
      check("R2 cleared", q, 0);
    end

    // R3 event colliding with exchange
    do_reset();
    pulse(3'd0, 16'h0002);
    ev_rx = 16'h0008;
    access(1, 1, 6'h00, 16'h0000, q);
    ev_rx = '0;
    check("R3 old value", q, 16'h0002);
    access(1, 0, 6'h00, 0, q);
    check("R3 kept bit", q, 16'h0008);

    // R5 R6 R7 doorbell handshake
    do_reset();
    pulse(3'd1, 16'h0020);
    check("R5 not yet", irq, 0);
    @(negedge clk);
    check("R5 raised", irq, 1);
    access(1, 0, 6'h05, 0, q); check("R6 db+ack", q, 16'h0003);
    access(0, 1, 6'h05, 16'h0001, q);
    check("R6 db cleared", irq, 0);
    repeat (3) @(negedge clk);
    check("R6 held off", irq, 0);
    access(1, 0, 6'h05, 0, q); check("R6 ack only", q, 16'h0002);
    access(0, 1, 6'h06, 16'h0002, q);
    access(1, 0, 6'h05, 0, q); check("R7 wrong code", q, 16'h0002);
    check("R7 wrong code irq", irq, 0);
    access(0, 1, 6'h06, 16'h0001, q);
    check("R7 ack edge", irq, 0);
    @(negedge clk);
    check("R7 re-raised", irq, 1);
    access(1, 1, 6'h01, 0, q); check("R2 tx word", q, 16'h0020);
    access(0, 1, 6'h05, 16'h0001, q);
    access(0, 1, 6'h06, 16'h0001, q);
    repeat (3) @(negedge clk);
    check("R5 idle no req", irq, 0);

    // R8 R4 mask
    access(0, 1, 6'h07, 16'h0017, q);
    pulse(3'd3, 16'h0001);
    repeat (3) @(negedge clk);
    check("R8 masked no irq", irq, 0);
    access(1, 0, 6'h03, 0, q); check("R8 accumulates", q, 16'h0001);
    access(1, 0, 6'h03, 0, q); check("R4 read keeps", q, 16'h0001);
    access(1, 0, 6'h07, 0, q); check("R8 mask read", q, 16'h0017);
    pulse(3'd4, 16'h8000);
    @(negedge clk);
    check("R8 enabled raises", irq, 1);

    // R9 command words
    do_reset();
    access(0, 1, 6'h22, 16'h00AB, q);
    check("R9 cmd out", cmd_word[2*CW +: CW], 16'h00AB);
    access(1, 0, 6'h22, 0, q); check("R9 cmd read", q, 16'h00AB);
    cmd_status[2*CW +: CW] = 16'h0005;
    pulse(3'd2, 16'h0004);
    check("R9 cmd cleared", cmd_word[2*CW +: CW], 0);
    access(1, 0, 6'h32, 0, q); check("R9 status", q, 16'h0005);
    access(1, 1, 6'h02, 0, q); check("R9 cmd req bit", q, 16'h0004);
    // completion beats same-cycle host write
    cmd_done = 16'h0004;
    access(0, 1, 6'h22, 16'h0077, q);
    cmd_done = '0;
    check("R9 done priority", cmd_word[2*CW +: CW], 0);

    summary();
  end
endmodule